// File: doc/BRIEF.md
# Node-Sync Quality Monitor

This block watches the health of a Viterbi decoder's symbol grouping and steps the grouping phase when that grouping looks wrong. Each strobe on `bit_valid_i` marks one decoded bit. On strobed cycles the block counts quality events from one of two sources, chosen by `alg_sel_i`. One source is a traceback-disagreement pulse and the other is a path-metric rescale pulse. Both are produced by the trellis logic outside the block.

Every 256 strobes close a window. The closing count is stored so it can be read. It is also compared against a threshold of 2 to the power of the 3-bit `thr_code_i`. When the count reaches the threshold, the block moves the 2-bit phase output to the next legal grouping and raises the loss flag. When the count stays under the threshold, the loss flag drops. The phase output is meant to feed the decoder's symbol-grouping select, either directly or through an external policy.

Top module: `node_sync_monitor`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `sync_state_o` is 00, `sync_lost_o` is 0 and `win_count_o` is 0.
- R2: A window closes on the 256th cycle in which `bit_valid_i` is high. Cycles with `bit_valid_i` low neither advance the window nor count events, even when the event inputs are high.
- R3: With `alg_sel_i`=1 only `mismatch_i` is counted. With `alg_sel_i`=0 only `renorm_i` is counted. The other input has no effect.
- R4: The threshold is 1 shifted left by `thr_code_i` (code 0 gives 1, code 7 gives 128). The code is sampled on the closing strobe.
- R5: When a window's count is greater than or equal to the threshold, `sync_state_o` steps 00→10→01→00 and `sync_lost_o` goes to 1. Both take effect in the cycle after the closing strobe.
- R6: When a window's count is below the threshold, `sync_state_o` holds and `sync_lost_o` goes to 0 in the cycle after the closing strobe.
- R7: `win_count_o` shows the count of the last complete window, including an event on the closing strobe. It updates in the cycle after the closing strobe and is constant at all other times.
- R8: The event count saturates at 255. A window with an event on every strobe reports 255.
- R9: `sync_state_o` never takes the value 11.
- R10: Each window starts counting from zero, so one window's count carries nothing into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | One decoded bit produced this cycle |
| alg_sel_i | input | 1 | 1: count traceback mismatches, 0: count metric rescales |
| mismatch_i | input | 1 | Traceback mismatch event |
| renorm_i | input | 1 | Metric renormalization event |
| thr_code_i | input | 3 | Threshold exponent |
| sync_state_o | output | 2 | Symbol grouping phase (00, 10, 01) |
| sync_lost_o | output | 1 | 1 when the last window judged sync lost |
| win_count_o | output | 8 | Event count of the last complete window |

## Verification
The hardest cases to reach are the exact threshold edges. For each code the window must close with a count of exactly threshold−1 or exactly threshold, and the 128 case needs half a window of events placed precisely. The bench builds each window strobe by strobe from a requested event count, so the closing count is known before the closing strobe. It sweeps every code at both edges while alternating the source select and flooding the unselected input. Gap cycles with both events high are woven between strobes to show that they are ignored. A full-window flood drives the count into saturation.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
  typedef logic [1:0] phase_t;

  localparam phase_t PH_A = 2'b00;
  localparam phase_t PH_B = 2'b10;
  localparam phase_t PH_C = 2'b01;

  function automatic phase_t next_phase(input phase_t cur);
    case (cur)
      PH_A:    return PH_B;
      PH_B:    return PH_C;
      default: return PH_A;
    endcase
  endfunction
endpackage

// File: rtl/nsm_window_timer.sv
module nsm_window_timer #(
  parameter int WIN_LEN = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_valid_i,
  output logic win_end_o
);
  localparam int IDX_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WIN_LEN - 1);

  logic [IDX_W-1:0] idx_q;

  assign win_end_o = bit_valid_i && (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          idx_q <= '0;
    else if (win_end_o)   idx_q <= '0;
    else if (bit_valid_i) idx_q <= idx_q + 1'b1;
  end
endmodule

// File: rtl/nsm_event_counter.sv
module nsm_event_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_valid_i,
  input  logic             alg_sel_i,
  input  logic             mismatch_i,
  input  logic             renorm_i,
  input  logic             win_end_i,
  output logic [CNT_W-1:0] final_cnt_o,
  output logic [CNT_W-1:0] snap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             evt;

  assign evt = bit_valid_i && (alg_sel_i ? mismatch_i : renorm_i);
  // running total including this cycle's event, clamped
  assign final_cnt_o = (evt && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      snap_o <= '0;
    end else if (win_end_i) begin
      cnt_q  <= '0;
      snap_o <= final_cnt_o;
    end else begin
      cnt_q  <= final_cnt_o;
    end
  end
endmodule

// File: rtl/nsm_phase_ctrl.sv
module nsm_phase_ctrl
  import nsm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int THR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_end_i,
  input  logic [CNT_W-1:0] final_cnt_i,
  input  logic [THR_W-1:0] thr_code_i,
  output phase_t           phase_o,
  output logic             lost_o
);
  localparam int NCODE = 1 << THR_W;
  localparam int VAL_W = CNT_W + 1;

  logic [VAL_W-1:0] thr_tab [NCODE];
  logic [VAL_W-1:0] thr;
  logic             hit;

  for (genvar g = 0; g < NCODE; g++) begin : g_thr
    assign thr_tab[g] = VAL_W'(1) << g;
  end

  assign thr = thr_tab[thr_code_i];
  assign hit = {1'b0, final_cnt_i} >= thr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= PH_A;
      lost_o  <= 1'b0;
    end else if (win_end_i) begin
      lost_o <= hit;
      if (hit) phase_o <= next_phase(phase_o);
    end
  end
endmodule

// File: rtl/node_sync_monitor.sv
module node_sync_monitor #(
  parameter int WIN_LEN = 256,
  parameter int CNT_W   = 8,
  parameter int THR_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_valid_i,
  input  logic             alg_sel_i,
  input  logic             mismatch_i,
  input  logic             renorm_i,
  input  logic [THR_W-1:0] thr_code_i,
  output logic [1:0]       sync_state_o,
  output logic             sync_lost_o,
  output logic [CNT_W-1:0] win_count_o
);
  logic             win_end;
  logic [CNT_W-1:0] final_cnt;

  nsm_window_timer #(.WIN_LEN(WIN_LEN)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_valid_i(bit_valid_i),
    .win_end_o  (win_end)
  );

  nsm_event_counter #(.CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_valid_i(bit_valid_i),
    .alg_sel_i  (alg_sel_i),
    .mismatch_i (mismatch_i),
    .renorm_i   (renorm_i),
    .win_end_i  (win_end),
    .final_cnt_o(final_cnt),
    .snap_o     (win_count_o)
  );

  nsm_phase_ctrl #(.CNT_W(CNT_W), .THR_W(THR_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_end_i  (win_end),
    .final_cnt_i(final_cnt),
    .thr_code_i (thr_code_i),
    .phase_o    (sync_state_o),
    .lost_o     (sync_lost_o)
  );
endmodule

// File: rtl/nsm_checker.sv
module nsm_checker #(
  parameter int CNT_W = 8,
  parameter int THR_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_valid_i,
  input logic [1:0]       sync_state_o,
  input logic             sync_lost_o,
  input logic [CNT_W-1:0] win_count_o
);
  p_no_state3_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_state_o != 2'b11);

  p_step_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sync_state_o) |->
      (($past(sync_state_o) == 2'b00 && sync_state_o == 2'b10) ||
       ($past(sync_state_o) == 2'b10 && sync_state_o == 2'b01) ||
       ($past(sync_state_o) == 2'b01 && sync_state_o == 2'b00)));

  p_step_sets_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sync_state_o) |-> sync_lost_o);

  p_hold_when_ok_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_lost_o |-> $stable(sync_state_o));

  p_flag_on_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sync_lost_o) |-> $past(bit_valid_i));

  p_count_on_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(win_count_o) |-> $past(bit_valid_i));
endmodule

bind node_sync_monitor nsm_checker #(.CNT_W(CNT_W), .THR_W(THR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_valid_i (bit_valid_i),
  .sync_state_o(sync_state_o),
  .sync_lost_o (sync_lost_o),
  .win_count_o (win_count_o)
);

// File: tb/node_sync_monitor_test.sv
`timescale 1ns/1ps
module node_sync_monitor_test;
  localparam int WIN = 256;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_valid_i = 1'b0;
  logic       alg_sel_i = 1'b0;
  logic       mismatch_i = 1'b0;
  logic       renorm_i = 1'b0;
  logic [2:0] thr_code_i = '0;
  logic [1:0] sync_state_o;
  logic       sync_lost_o;
  logic [7:0] win_count_o;

  int errors = 0;
  int checks = 0;
  int exp_state = 0;
  int exp_lost = 0;
  int exp_cnt = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  node_sync_monitor uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_valid_i(bit_valid_i),
    .alg_sel_i(alg_sel_i), .mismatch_i(mismatch_i), .renorm_i(renorm_i),
    .thr_code_i(thr_code_i), .sync_state_o(sync_state_o),
    .sync_lost_o(sync_lost_o), .win_count_o(win_count_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int step(input int s);
    if (s == 0) return 2;
    if (s == 2) return 1;
    return 0;
  endfunction

  task automatic check_outputs(input string req);
    chk({req, " win_count"}, int'(win_count_o), exp_cnt);
    chk({req, " sync_lost"}, int'(sync_lost_o), exp_lost);
    chk({req, " sync_state"}, int'(sync_state_o), exp_state);
  endtask

  // one window: n_sel events on the selected source, n_oth on the other
  task automatic run_window(input int n_sel, input int n_oth, input bit alg,
                            input int code, input bit gaps, input string req);
    int cnt;
    alg_sel_i  = alg;
    thr_code_i = 3'(code);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk_i);
      if (i == WIN - 1)
        chk({req, " R7 count held mid-window"}, int'(win_count_o), exp_cnt);
      bit_valid_i = 1'b1;
      mismatch_i  = alg ? (i < n_sel) : (i < n_oth);
      renorm_i    = alg ? (i < n_oth) : (i < n_sel);
      if (gaps && i != WIN - 1) begin
        @(negedge clk_i);
        bit_valid_i = 1'b0;
        mismatch_i  = 1'b1;
        renorm_i    = 1'b1;
      end
    end
    @(negedge clk_i);
    bit_valid_i = 1'b0;
    mismatch_i  = 1'b0;
    renorm_i    = 1'b0;
    cnt = (n_sel > 255) ? 255 : n_sel;
    exp_cnt = cnt;
    if (cnt >= (1 << code)) begin
      exp_state = step(exp_state);
      exp_lost  = 1;
    end else begin
      exp_lost = 0;
    end
    check_outputs(req);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #15;
    check_outputs("R1 in reset");
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_outputs("R1 after release");

    // R3: unselected source flooded, selected quiet, mismatch path
    run_window(0, WIN, 1'b1, 0, 1'b0, "R3 mismatch sel");
    // R3: renorm path
    run_window(0, WIN, 1'b0, 0, 1'b0, "R3 renorm sel");

    // R4 R5 R6 R9: every code at threshold-1 and threshold
    for (int c = 0; c < 8; c++) begin
      run_window((1 << c) - 1, 17, c[0], c, 1'b0, "R4 R6 below thr");
      run_window(1 << c, 200, ~c[0], c, 1'b0, "R4 R5 at thr");
      chk("R9 no illegal phase", int'(sync_state_o == 2'b11), 0);
    end

    // R2: idle cycles with both events high are ignored
    run_window(5, 0, 1'b1, 2, 1'b1, "R2 gaps ignored");
    run_window(3, 0, 1'b0, 2, 1'b1, "R2 gaps no step");

    // R8: saturation
    run_window(WIN, WIN, 1'b1, 7, 1'b0, "R8 saturate");

    // R10: next window starts from zero
    run_window(40, 0, 1'b0, 7, 1'b0, "R10 prior window");
    run_window(2, 0, 1'b0, 1, 1'b0, "R10 fresh window");

    // R5: wrap phase fully once more
    for (int k = 0; k < 3; k++)
      run_window(1, 0, 1'b1, 0, 1'b0, "R5 phase cycle");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule